// File: doc/BRIEF.md
# Register Alias Table with Superseded-Mapping Tracking

This block holds the architectural-to-physical register map of a small out-of-order core. Each architectural register has an entry with the physical register that will hold its newest value and a location bit. The location bit tells the operand path where the committed value lives: in the reorder buffer (0) or in the architectural register file (1). A group of up to `GROUP` instructions is renamed per cycle. Each instruction in the group has two source lookups and one destination remap.

A second structure is a vector with one bit per physical register. The bit is set once the architectural name that physical register was allocated for has been given to a newer physical register. A query port is driven one cycle before a result is written back. It answers whether that result is short-lived: no later instruction can name it any more, so it need not be kept in a small result cache. Commit updates move an entry back to the register file location. A flush returns the whole table to its identity state.

Top module: `rename_map`

## Requirements
- R1: After reset every architectural register `a` maps to physical `a` with location 1 (register file), every superseded bit is 0, and `q_short` is 0 for every physical index.
- R2: Source lookups are combinational. They return the physical number and the location bit (0 = reorder buffer, 1 = register file) held at the start of the cycle. A rename becomes visible to lookups from the next cycle on.
- R3: A valid rename of architectural `d` to physical `p` makes the entry for `d` read `p` with location 0 from the next cycle on. It also clears the superseded bit of `p`.
- R4: A valid rename sets the superseded bit of the physical register that `d` mapped to before it. `q_short` equals the superseded bit of `q_phys` in the same cycle. The superseded vector changes only on rename or flush. Example: remapping register 1 from 31 to 33 makes a query of 31 report 1 and a query of 33 report 0.
- R5: Within one group, slot `i`'s lookups see the new mappings of older slots `j < i` (as location 0) and not those of slot `i` or younger. When two slots rename the same register, the younger mapping wins. The older slot's new physical register is marked superseded.
- R6: A commit of (`cm_arch`, `cm_phys`) sets the location of `cm_arch` to 1 only when its current mapping equals `cm_phys`. A stale commit has no effect. A rename of the same register in the same cycle takes precedence and leaves location 0.
- R7: A flush restores every entry to the identity mapping with location 1 and clears the whole superseded vector. It overrides renames and commits in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore identity state |
| ren_valid | input | GROUP | Per-slot rename enable |
| ren_dst | input | GROUP*AW | Per-slot destination architectural register |
| ren_new | input | GROUP*PW | Per-slot newly allocated physical register |
| src_a | input | GROUP*AW | Per-slot first source architectural register |
| src_b | input | GROUP*AW | Per-slot second source architectural register |
| phys_a | output | GROUP*PW | Physical register for first source |
| loc_a | output | GROUP | Location bit for first source |
| phys_b | output | GROUP*PW | Physical register for second source |
| loc_b | output | GROUP | Location bit for second source |
| cm_valid | input | 1 | Commit update enable |
| cm_arch | input | AW | Committing architectural register |
| cm_phys | input | PW | Committing physical register |
| q_phys | input | PW | Physical destination queried before writeback |
| q_short | output | 1 | Queried result is short-lived |

## Verification
A single-slot sequence renames register 1 to 31, then register 5 to 32, then register 1 to 33. Lookups and queries are interleaved with the renames. This separates the pre-edge view from the post-edge view and a superseded register from its successor. Two-slot groups are then driven: one renames the same register in both slots and reads it from both slots. This separates correct in-group forwarding from reading stale or too-new state. Stale and matching commits, a commit racing a rename, and a flush racing a rename cover the precedence rules.

// File: rtl/rename_map.sv
module rename_map #(
  parameter int ARCH_REGS = 8,
  parameter int PHYS_REGS = 40,
  parameter int GROUP     = 2,
  localparam int AW = $clog2(ARCH_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic [GROUP-1:0]    ren_valid,
  input  logic [GROUP*AW-1:0] ren_dst,
  input  logic [GROUP*PW-1:0] ren_new,
  input  logic [GROUP*AW-1:0] src_a,
  input  logic [GROUP*AW-1:0] src_b,
  output logic [GROUP*PW-1:0] phys_a,
  output logic [GROUP-1:0]    loc_a,
  output logic [GROUP*PW-1:0] phys_b,
  output logic [GROUP-1:0]    loc_b,
  input  logic                cm_valid,
  input  logic [AW-1:0]       cm_arch,
  input  logic [PW-1:0]       cm_phys,
  input  logic [PW-1:0]       q_phys,
  output logic                q_short
);

  logic [PW-1:0]        map_q [ARCH_REGS];
  logic [ARCH_REGS-1:0] loc_q;
  logic [PHYS_REGS-1:0] sup_q;

  logic [PW-1:0]        map_d [ARCH_REGS];
  logic [ARCH_REGS-1:0] loc_d;
  logic [PHYS_REGS-1:0] sup_d;
  logic [PW-1:0]        prev_p [GROUP];
  logic [ARCH_REGS-1:0] ren_hit;

  assign q_short = sup_q[q_phys];

  always_comb begin
    for (int i = 0; i < GROUP; i++) begin
      logic [AW-1:0] sa, sb, sd;
      logic [PW-1:0] pa, pb, pd;
      logic la, lb;
      sa = src_a[i*AW +: AW];
      sb = src_b[i*AW +: AW];
      sd = ren_dst[i*AW +: AW];
      pa = map_q[sa]; la = loc_q[sa];
      pb = map_q[sb]; lb = loc_q[sb];
      pd = map_q[sd];
      for (int j = 0; j < i; j++) begin
        if (ren_valid[j] && ren_dst[j*AW +: AW] == sa) begin
          pa = ren_new[j*PW +: PW]; la = 1'b0;
        end
        if (ren_valid[j] && ren_dst[j*AW +: AW] == sb) begin
          pb = ren_new[j*PW +: PW]; lb = 1'b0;
        end
        if (ren_valid[j] && ren_dst[j*AW +: AW] == sd)
          pd = ren_new[j*PW +: PW];
      end
      phys_a[i*PW +: PW] = pa;
      loc_a[i]           = la;
      phys_b[i*PW +: PW] = pb;
      loc_b[i]           = lb;
      prev_p[i]          = pd;
    end
  end

  always_comb begin
    map_d   = map_q;
    loc_d   = loc_q;
    sup_d   = sup_q;
    ren_hit = '0;
    if (cm_valid && map_q[cm_arch] == cm_phys)
      loc_d[cm_arch] = 1'b1;
    for (int i = 0; i < GROUP; i++) begin
      if (ren_valid[i]) begin
        sup_d[ren_new[i*PW +: PW]]   = 1'b0;
        sup_d[prev_p[i]]             = 1'b1;
        map_d[ren_dst[i*AW +: AW]]   = ren_new[i*PW +: PW];
        loc_d[ren_dst[i*AW +: AW]]   = 1'b0;
        ren_hit[ren_dst[i*AW +: AW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int a = 0; a < ARCH_REGS; a++) map_q[a] <= PW'(a);
      loc_q <= '1;
      sup_q <= '0;
    end else begin
      map_q <= map_d;
      loc_q <= loc_d;
      sup_q <= sup_d;
    end
  end

  AST_FLUSH_CLEARS_SUP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (sup_q == '0)); // R7
  AST_FLUSH_SETS_LOC: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (&loc_q)); // R7
  AST_SUP_ONLY_ON_RENAME: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && ren_valid == '0) |=> $stable(sup_q)); // R4

  for (genvar a = 0; a < ARCH_REGS; a++) begin : g_loc_chk
    AST_LOC_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loc_q[a]) |-> $past(ren_hit[a])); // R3
    AST_LOC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(loc_q[a]) |-> $past(flush || (cm_valid && cm_arch == AW'(a)))); // R6
  end

endmodule

// File: tb/tb_rename_map.sv
module tb_rename_map;
  localparam int AR = 8, PR = 40, G = 2, AW = 3, PW = 6;

  logic clk = 1'b0;
  logic rst_n, flush, cm_valid, q_short;
  logic [G-1:0] ren_valid, loc_a, loc_b;
  logic [G*AW-1:0] ren_dst, src_a, src_b;
  logic [G*PW-1:0] ren_new, phys_a, phys_b;
  logic [AW-1:0] cm_arch;
  logic [PW-1:0] cm_phys, q_phys;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  rename_map #(.ARCH_REGS(AR), .PHYS_REGS(PR), .GROUP(G)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .ren_valid(ren_valid),
    .ren_dst(ren_dst), .ren_new(ren_new), .src_a(src_a), .src_b(src_b),
    .phys_a(phys_a), .loc_a(loc_a), .phys_b(phys_b), .loc_b(loc_b),
    .cm_valid(cm_valid), .cm_arch(cm_arch), .cm_phys(cm_phys),
    .q_phys(q_phys), .q_short(q_short));

  // {valid, dst, new, src, exp_phys, exp_loc, query, exp_short}
  localparam logic [26:0] TBL [6] = '{
    {1'b1, 3'd1, 6'd31, 3'd1, 6'd1,  1'b1, 6'd1,  1'b0},
    {1'b1, 3'd5, 6'd32, 3'd1, 6'd31, 1'b0, 6'd1,  1'b1},
    {1'b1, 3'd1, 6'd33, 3'd5, 6'd32, 1'b0, 6'd31, 1'b0},
    {1'b0, 3'd0, 6'd0,  3'd1, 6'd33, 1'b0, 6'd31, 1'b1},
    {1'b0, 3'd0, 6'd0,  3'd2, 6'd2,  1'b1, 6'd33, 1'b0},
    {1'b1, 3'd2, 6'd34, 3'd2, 6'd2,  1'b1, 6'd32, 1'b0}
  };

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; ren_valid = '0; ren_dst = '0; ren_new = '0;
    src_a = '0; src_b = '0; cm_valid = 0; cm_arch = '0; cm_phys = '0; q_phys = '0;
  endtask

  task automatic look(string req, int a, int ep, int el);
    @(negedge clk); idle(); src_a[AW-1:0] = AW'(a); #1;
    chk(req, phys_a[PW-1:0], ep); chk(req, loc_a[0], el);
  endtask

  task automatic query(string req, int p, int e);
    @(negedge clk); idle(); q_phys = PW'(p); #1;
    chk(req, q_short, e);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(); rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    look("R1", 0, 0, 1); look("R1", 7, 7, 1); look("R1", 3, 3, 1);
    query("R1", 0, 0); query("R1", 5, 0);
    @(negedge clk); idle(); src_b[AW +: AW] = 3'd6; #1;
    chk("R1", phys_b[PW +: PW], 6); chk("R1", loc_b[1], 1);

    for (int k = 0; k < 6; k++) begin
      @(negedge clk); idle();
      ren_valid[0] = TBL[k][26]; ren_dst[AW-1:0] = TBL[k][25:23];
      ren_new[PW-1:0] = TBL[k][22:17]; src_a[AW-1:0] = TBL[k][16:14];
      q_phys = TBL[k][6:1]; #1;
      chk("R2", phys_a[PW-1:0], int'(TBL[k][13:8]));
      chk("R3", loc_a[0], int'(TBL[k][7]));
      chk("R4", q_short, int'(TBL[k][0]));
    end

    // R5: same register renamed in both slots, read from both slots
    @(negedge clk); idle();
    ren_valid = 2'b11;
    ren_dst = {3'd3, 3'd3}; ren_new = {6'd36, 6'd35};
    src_a = {3'd3, 3'd3}; src_b = {3'd1, 3'd6}; #1;
    chk("R5", phys_a[PW-1:0], 3);   chk("R5", loc_a[0], 1);
    chk("R5", phys_a[PW +: PW], 35); chk("R5", loc_a[1], 0);
    chk("R5", phys_b[PW +: PW], 33); chk("R5", loc_b[1], 0);
    look("R5", 3, 36, 0);
    query("R5", 35, 1); query("R5", 36, 0); query("R5", 3, 1);

    // R6: stale commit, matching commit, commit racing a rename
    @(negedge clk); idle(); cm_valid = 1; cm_arch = 3'd1; cm_phys = 6'd31;
    look("R6", 1, 33, 0);
    @(negedge clk); idle(); cm_valid = 1; cm_arch = 3'd1; cm_phys = 6'd33;
    look("R6", 1, 33, 1);
    @(negedge clk); idle(); cm_valid = 1; cm_arch = 3'd3; cm_phys = 6'd36;
    ren_valid[0] = 1; ren_dst[AW-1:0] = 3'd3; ren_new[PW-1:0] = 6'd37;
    look("R6", 3, 37, 0);

    // R7: flush racing a rename
    @(negedge clk); idle(); flush = 1;
    ren_valid[0] = 1; ren_dst[AW-1:0] = 3'd4; ren_new[PW-1:0] = 6'd38;
    look("R7", 4, 4, 1); look("R7", 1, 1, 1); look("R7", 3, 3, 1);
    query("R7", 31, 0); query("R7", 36, 0); query("R7", 1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule